// File: doc/BRIEF.md
# System control port register

This block is a single byte-wide control register on a simple I/O bus. It answers one fixed I/O address, keeps the last byte written there, and returns that byte on reads. Two of its bits have side effects. Bit 1 drives the gate for memory address line 20. When a write raises bit 0 from 0 to 1, the block sends a one-cycle reset request to the system.

The block has two reset inputs. Power-on reset clears the whole byte. Warm reset clears only the request bit and keeps the gate setting and the other bits. A reset controller elsewhere acts on the request pulse. The gate output is meant to be combined with any other source that controls address line 20.

Top module: `sys_ctl_port`

## Requirements
- R1: While power-on reset is asserted (por_n low), the stored byte is 0x00, a20_gate is 0 and reset_req is 0.
- R2: A write (wr_en high) to address 0x0092 stores all 8 bits of wdata. A read (rd_en high) at that address returns the stored byte on rdata in the same cycle.
- R3: A write to any other address leaves the stored byte unchanged. rdata is 0x00 whenever the address differs from 0x0092 or rd_en is low.
- R4: a20_gate equals bit 1 of the stored byte. It shows the new value in the cycle after the write.
- R5: A write to 0x0092 with wdata bit 0 set raises reset_req for exactly one cycle, in the cycle after the write, when the stored bit 0 was 0.
- R6: A write with wdata bit 0 set while the stored bit 0 is already 1 does not raise reset_req.
- R7: A warm reset cycle (warm_rst high) clears bit 0 of the stored byte and keeps bits 7..1, so a20_gate is unchanged.
- R8: When power-on reset and warm reset are asserted together, the whole byte clears to 0x00.
- R9: Writing 0 and then 1 to bit 0 in back-to-back cycles gives exactly one reset_req pulse.
- R10: A write in the same cycle as a warm reset is discarded and raises no reset_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| warm_rst | input | 1 | Warm device reset, active high, synchronous |
| addr | input | 16 | I/O address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| a20_gate | output | 1 | Address line 20 gate |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with its default parameters: a 16-bit address, port 0x0092, an 8-bit register, the gate on bit 1 and the request on bit 0. With a 16-bit address, the bench can use both a near miss in the low byte (0x0093) and a miss that differs only in a high bit (0x0192), so the decoder must compare every address bit. With the default bit positions, one byte can move the gate and the request bit in the same write. This exposes any mix-up between the two bits, both on warm reset and in edge detection.

// File: rtl/sys_ctl_pkg.sv
package sys_ctl_pkg;
   localparam int unsigned SCP_ADDR_W = 16;
   localparam logic [SCP_ADDR_W-1:0] SCP_PORT = 16'h0092;

   // Rising transition from the held value to the incoming value.
   function automatic logic scp_rise(input logic was, input logic now);
      return now & ~was;
   endfunction
endpackage

// File: rtl/sys_ctl_decode.sv
module sys_ctl_decode #(
   parameter int unsigned          ADDR_W    = 16,
   parameter logic [ADDR_W-1:0]    PORT_ADDR = 16'h0092
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic              wr_hit,
   output logic              rd_hit
);
   logic match;

   assign match  = (addr == PORT_ADDR);
   assign wr_hit = wr_en & match;
   assign rd_hit = rd_en & match;
endmodule

// File: rtl/sys_ctl_store.sv
module sys_ctl_store #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned KICK_BIT = 0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              warm_rst,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic bit_q;
      if (i == KICK_BIT) begin : g_clear_on_warm
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)        bit_q <= 1'b0;
            else if (warm_rst) bit_q <= 1'b0;
            else if (wr_hit)   bit_q <= wdata[i];
         end
      end else begin : g_keep_on_warm
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)                   bit_q <= 1'b0;
            else if (!warm_rst && wr_hit) bit_q <= wdata[i];
         end
      end
      assign q[i] = bit_q;
   end
endmodule

// File: rtl/sys_ctl_kick.sv
module sys_ctl_kick (
   input  logic clk,
   input  logic por_n,
   input  logic warm_rst,
   input  logic wr_hit,
   input  logic held_bit,
   input  logic new_bit,
   output logic pulse
);
   import sys_ctl_pkg::*;

   logic pulse_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) pulse_q <= 1'b0;
      else        pulse_q <= ~warm_rst & wr_hit & scp_rise(held_bit, new_bit);
   end

   assign pulse = pulse_q;
endmodule

// File: rtl/sys_ctl_port.sv
module sys_ctl_port #(
   parameter int unsigned       ADDR_W    = sys_ctl_pkg::SCP_ADDR_W,
   parameter logic [ADDR_W-1:0] PORT_ADDR = sys_ctl_pkg::SCP_PORT,
   parameter int unsigned       DATA_W    = 8,
   parameter int unsigned       GATE_BIT  = 1,
   parameter int unsigned       KICK_BIT  = 0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              warm_rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              a20_gate,
   output logic              reset_req
);
   localparam logic [DATA_W-1:0] ZERO = '0;

   if (DATA_W < 2) begin : g_bad_width
      $error("sys_ctl_port: DATA_W must be at least 2");
   end
   if (GATE_BIT >= DATA_W || KICK_BIT >= DATA_W) begin : g_bad_bit
      $error("sys_ctl_port: bit positions must lie inside DATA_W");
   end
   if (GATE_BIT == KICK_BIT) begin : g_bad_overlap
      $error("sys_ctl_port: gate and request bits must differ");
   end

   logic              wr_hit;
   logic              rd_hit;
   logic [DATA_W-1:0] store_q;

   sys_ctl_decode #(
      .ADDR_W   (ADDR_W),
      .PORT_ADDR(PORT_ADDR)
   ) u_decode (
      .addr  (addr),
      .wr_en (wr_en),
      .rd_en (rd_en),
      .wr_hit(wr_hit),
      .rd_hit(rd_hit)
   );

   sys_ctl_store #(
      .DATA_W  (DATA_W),
      .KICK_BIT(KICK_BIT)
   ) u_store (
      .clk     (clk),
      .por_n   (por_n),
      .warm_rst(warm_rst),
      .wr_hit  (wr_hit),
      .wdata   (wdata),
      .q       (store_q)
   );

   sys_ctl_kick u_kick (
      .clk     (clk),
      .por_n   (por_n),
      .warm_rst(warm_rst),
      .wr_hit  (wr_hit),
      .held_bit(store_q[KICK_BIT]),
      .new_bit (wdata[KICK_BIT]),
      .pulse   (reset_req)
   );

   assign rdata    = rd_hit ? store_q : ZERO;
   assign a20_gate = store_q[GATE_BIT];
endmodule

// File: rtl/sys_ctl_port_chk.sv
module sys_ctl_port_chk #(
   parameter int unsigned       ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092,
   parameter int unsigned       DATA_W    = 8,
   parameter int unsigned       GATE_BIT  = 1,
   parameter int unsigned       KICK_BIT  = 0
) (
   input logic              clk,
   input logic              por_n,
   input logic              warm_rst,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              a20_gate,
   input logic              reset_req,
   input logic [DATA_W-1:0] store
);
   logic hit_wr;
   assign hit_wr = wr_en && (addr == PORT_ADDR) && !warm_rst;

   AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
      reset_req |=> !reset_req); // R5

   AST_REQ_ON_RISE: assert property (@(posedge clk) disable iff (!por_n)
      (hit_wr && wdata[KICK_BIT] && !store[KICK_BIT]) |=> reset_req); // R5

   AST_NO_REQ_WHEN_HELD: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && (addr == PORT_ADDR) && store[KICK_BIT]) |=> !reset_req); // R6

   AST_GATE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!por_n)
      hit_wr |=> (a20_gate == $past(wdata[GATE_BIT]))); // R4

   AST_WARM_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!por_n)
      warm_rst |=> (!store[KICK_BIT] && a20_gate == $past(a20_gate)
                    && !reset_req)); // R7

   AST_MISS_NO_STORE: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && (addr != PORT_ADDR) && !warm_rst) |=> $stable(store)); // R3

   AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!por_n)
      ((addr != PORT_ADDR) || !rd_en) |-> (rdata == '0)); // R3
endmodule

bind sys_ctl_port sys_ctl_port_chk #(
   .ADDR_W   (ADDR_W),
   .PORT_ADDR(PORT_ADDR),
   .DATA_W   (DATA_W),
   .GATE_BIT (GATE_BIT),
   .KICK_BIT (KICK_BIT)
) u_chk (
   .clk      (clk),
   .por_n    (por_n),
   .warm_rst (warm_rst),
   .addr     (addr),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .wdata    (wdata),
   .rdata    (rdata),
   .a20_gate (a20_gate),
   .reset_req(reset_req),
   .store    (store_q)
);

// File: tb/sys_ctl_port_test.sv
module sys_ctl_port_test;
   localparam int CLK_PER = 10;
   localparam logic [15:0] PORT = 16'h0092;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        warm_rst = 1'b0;
   logic [15:0] addr = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        a20_gate;
   logic        reset_req;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   sys_ctl_port uut (
      .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .addr(addr),
      .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
      .a20_gate(a20_gate), .reset_req(reset_req)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Write one byte; returns at the falling edge after the capturing edge.
   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      rd_en = 1'b0;
   endtask

   task automatic t_power_on();
      logic [7:0] v;
      check("R1 rdata", rdata, 8'h00);
      check("R1 a20_gate", {7'b0, a20_gate}, 8'h00);
      check("R1 reset_req", {7'b0, reset_req}, 8'h00);
      @(negedge clk); por_n = 1'b1;
      bus_read(PORT, v);
      check("R1 stored after release", v, 8'h00);
   endtask

   task automatic t_write_read();
      logic [7:0] v;
      bus_write(PORT, 8'h5A);
      check("R5 no pulse bit0 low", {7'b0, reset_req}, 8'h00);
      check("R4 gate set", {7'b0, a20_gate}, 8'h01);
      bus_read(PORT, v);
      check("R2 read 5A", v, 8'h5A);
      bus_write(PORT, 8'hA5);
      check("R5 pulse on rise", {7'b0, reset_req}, 8'h01);
      check("R4 gate cleared", {7'b0, a20_gate}, 8'h00);
      @(negedge clk);
      check("R5 pulse one cycle", {7'b0, reset_req}, 8'h00);
      bus_read(PORT, v);
      check("R2 read A5", v, 8'hA5);
   endtask

   task automatic t_miss();
      logic [7:0] v;
      bus_write(16'h0093, 8'hFF);
      bus_write(16'h0192, 8'h02);
      check("R3 gate untouched", {7'b0, a20_gate}, 8'h00);
      bus_read(PORT, v);
      check("R3 store untouched", v, 8'hA5);
      bus_read(16'h0093, v);
      check("R3 miss read zero", v, 8'h00);
      @(negedge clk); addr = PORT; rd_en = 1'b0;
      #1 check("R3 idle read zero", rdata, 8'h00);
   endtask

   task automatic t_held();
      bus_write(PORT, 8'h01);
      check("R6 no pulse when held", {7'b0, reset_req}, 8'h00);
      bus_write(PORT, 8'hC3);
      check("R6 no pulse again", {7'b0, reset_req}, 8'h00);
   endtask

   task automatic t_warm();
      logic [7:0] v;
      @(negedge clk); warm_rst = 1'b1;
      @(negedge clk); warm_rst = 1'b0;
      bus_read(PORT, v);
      check("R7 warm keeps upper", v, 8'hC2);
      check("R7 gate kept", {7'b0, a20_gate}, 8'h01);
      bus_write(PORT, 8'hC3);
      check("R5 pulse after warm", {7'b0, reset_req}, 8'h01);
   endtask

   task automatic t_warm_write();
      logic [7:0] v;
      @(negedge clk);
      warm_rst = 1'b1; addr = PORT; wdata = 8'h3D; wr_en = 1'b1;
      @(negedge clk);
      warm_rst = 1'b0; wr_en = 1'b0;
      check("R10 no pulse", {7'b0, reset_req}, 8'h00);
      bus_read(PORT, v);
      check("R10 write discarded", v, 8'hC2);
   endtask

   task automatic t_back_to_back();
      int pulses = 0;
      bus_write(PORT, 8'h03);
      @(negedge clk);
      addr = PORT; wdata = 8'h02; wr_en = 1'b1;
      @(negedge clk);
      if (reset_req) pulses++;
      wdata = 8'h03;
      @(negedge clk);
      wr_en = 1'b0;
      if (reset_req) pulses++;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         if (reset_req) pulses++;
      end
      check("R9 one pulse", pulses[7:0], 8'd1);
   endtask

   task automatic t_both_resets();
      logic [7:0] v;
      @(negedge clk); warm_rst = 1'b1; por_n = 1'b0;
      #1 check("R8 gate cleared", {7'b0, a20_gate}, 8'h00);
      @(negedge clk); warm_rst = 1'b0; por_n = 1'b1;
      bus_read(PORT, v);
      check("R8 all cleared", v, 8'h00);
   endtask

   initial begin
      #(CLK_PER * 100000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #1;
      t_power_on();
      t_write_read();
      t_miss();
      t_held();
      t_warm();
      t_warm_write();
      t_back_to_back();
      t_both_resets();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule